// File: doc/BRIEF.md
# Right-Justified Stereo Serial Audio Receiver

This block takes a three-wire stereo audio stream and delivers parallel sample pairs. The three wires are a bit clock, a channel-select framing line and a serial data line. All three are sampled in the system clock domain. A rising bit-clock edge is found by comparing successive synchronized samples. On each such edge the receiver captures one data bit, MSB first, and counts how many bit clocks the current half-frame has lasted. The framing line is high while the left channel is sent and low while the right channel is sent. A frame is a right half followed by a left half, so the falling edge of the framing line closes the frame.

In normal mode each half-frame lasts 32 bit clocks. The sample sits at the end of the half, so its first bit comes later the shorter the selected word is. In packed mode each half lasts 16 bit clocks and a 16-bit sample fills the whole half. When a frame closes, the left and right samples are staged. They reach the outputs, together with a one-cycle valid strobe, on the second rising bit-clock edge after the falling framing edge. A half-frame of the wrong length raises a one-cycle error flag, and the pair that contains it is dropped.

Top module: `rjrx_top`

## Requirements
- R1: After reset both samples read 0, and `pair_valid` and `frame_err` are 0. No pair is delivered and no error is flagged before the first framing transition seen after reset. The first pair delivered is the first frame that lies wholly after that transition.
- R2: Data is sampled on rising `bit_clk` edges, MSB first. The right sample is sent while `frame_sel` is 0 and the left sample while it is 1. A pair is the right half followed by the left half, and the frame is closed by the 1-to-0 transition of `frame_sel`.
- R3: With `pack_mode`=0 a half-frame lasts 32 bit clocks. `word_len` selects the sample width: 00 = 24 bits, 01 = 20, 10 = 18, 11 = 16. The sample is the last W bits of the half, starting at bit index 32-W when the first bit clock after the transition is index 0. Bits before that index are ignored.
- R4: Samples narrower than 24 bits are two's complement values, sign-extended to 24 bits at the outputs.
- R5: Both outputs change only in the cycle where `pair_valid` is 1. That strobe lasts one clock and follows the second rising `bit_clk` edge after the falling `frame_sel` edge that closed the frame.
- R6: With `pack_mode`=1 a half-frame lasts 16 bit clocks and carries a 16-bit sample. Its MSB is on the first bit clock after the transition. `word_len` has no effect in this mode.
- R7: A half-frame that starts at a transition but does not last the mode's length (32 or 16 bit clocks) raises `frame_err` for one clock after the transition that ends it. The pair containing that half is not delivered.
- R8: After a length error, the next frame whose halves both have the correct length is delivered normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_clk | input | 1 | Serial bit clock |
| frame_sel | input | 1 | Channel framing line: 1 = left, 0 = right |
| ser_data | input | 1 | Serial sample data, MSB first |
| pack_mode | input | 1 | 1 = 16-clock half-frames, 0 = 32-clock half-frames |
| word_len | input | 2 | Sample width code in normal mode |
| left_sample | output | 24 | Sign-extended left sample |
| right_sample | output | 24 | Sign-extended right sample |
| pair_valid | output | 1 | One-cycle strobe when a new pair appears |
| frame_err | output | 1 | One-cycle flag for a half-frame of wrong length |

## Verification
Some internal faults show up as a wrong sample value within the next frame. A bit counter that is off by one, a wrong start index or a broken sign extension all do this. A framing tracker that loses its place shows up differently. A pair goes missing or an error flag appears at the end of the first affected half-frame, which is at most 32 bit clocks later. A staging fault moves the valid strobe away from the second bit-clock edge after the frame closes. The bench therefore counts bit clocks from each falling framing edge and compares that count when the strobe arrives. Word widths, value extremes, the ignored leading bits and the length errors are swept in both modes.

// File: rtl/rjrx_pkg.sv
package rjrx_pkg;

  localparam int unsigned MAX_W      = 24;
  localparam int unsigned PACK_W     = 16;
  localparam int unsigned HALF_NORM  = 32;
  localparam int unsigned HALF_PACK  = 16;
  localparam int unsigned WIDTH_BITS = $clog2(MAX_W + 1);
  localparam int unsigned CNT_W      = $clog2(2 * HALF_NORM);

  typedef enum logic [1:0] {
    WL_24 = 2'b00,
    WL_20 = 2'b01,
    WL_18 = 2'b10,
    WL_16 = 2'b11
  } wlen_e;

  function automatic logic [WIDTH_BITS-1:0] sample_bits(input logic pack, input wlen_e wl);
    logic [WIDTH_BITS-1:0] w;
    if (pack) begin
      w = WIDTH_BITS'(PACK_W);
    end else begin
      case (wl)
        WL_24:   w = WIDTH_BITS'(24);
        WL_20:   w = WIDTH_BITS'(20);
        WL_18:   w = WIDTH_BITS'(18);
        default: w = WIDTH_BITS'(16);
      endcase
    end
    return w;
  endfunction

endpackage

// File: rtl/rjrx_sync.sv
module rjrx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic lrck_i,
  input  logic sd_i,
  output logic tick_o,
  output logic lr_o,
  output logic sd_o
);

  logic [2:0] pipe_q [STAGES];
  logic       bclk_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
      bclk_prev_q <= 1'b0;
    end else begin
      pipe_q[0] <= {bclk_i, lrck_i, sd_i};
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
      bclk_prev_q <= pipe_q[STAGES-1][2];
    end
  end

  assign tick_o = pipe_q[STAGES-1][2] & ~bclk_prev_q;
  assign lr_o   = pipe_q[STAGES-1][1];
  assign sd_o   = pipe_q[STAGES-1][0];

endmodule

// File: rtl/rjrx_framer.sv
module rjrx_framer
  import rjrx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic lr_i,
  input  logic pack_i,
  output logic cap_right_o,
  output logic go_o,
  output logic err_o
);

  logic             primed_q, primed_d;
  logic             lr_prev_q, lr_prev_d;
  logic             seen_q, seen_d;
  logic             right_ok_q, right_ok_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] exp_len;
  logic             edge_c, len_ok;

  always_comb begin
    exp_len     = pack_i ? CNT_W'(HALF_PACK) : CNT_W'(HALF_NORM);
    edge_c      = tick_i && primed_q && (lr_i != lr_prev_q);
    len_ok      = (cnt_q == exp_len);
    cap_right_o = edge_c && lr_i;
    go_o        = edge_c && !lr_i && seen_q && len_ok && right_ok_q;
    err_o       = edge_c && seen_q && !len_ok;

    primed_d   = primed_q | tick_i;
    lr_prev_d  = tick_i ? lr_i : lr_prev_q;
    seen_d     = seen_q | edge_c;
    cnt_d      = cnt_q;
    right_ok_d = right_ok_q;
    if (tick_i) begin
      if (edge_c)              cnt_d = CNT_W'(1);
      else if (cnt_q != '1)    cnt_d = cnt_q + 1'b1;
    end
    if (edge_c) right_ok_d = lr_i ? (seen_q && len_ok) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q   <= 1'b0;
      lr_prev_q  <= 1'b0;
      seen_q     <= 1'b0;
      right_ok_q <= 1'b0;
      cnt_q      <= '0;
    end else begin
      primed_q   <= primed_d;
      lr_prev_q  <= lr_prev_d;
      seen_q     <= seen_d;
      right_ok_q <= right_ok_d;
      cnt_q      <= cnt_d;
    end
  end

  // R2: once framing is found, the half-frame counter never reads zero
  p_cnt_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (cnt_q != '0));

  // R1: no error can be reported before the first transition has been seen
  p_no_early_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> !err_o);

endmodule

// File: rtl/rjrx_shift.sv
module rjrx_shift
  import rjrx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic                  sd_i,
  input  logic [WIDTH_BITS-1:0] width_i,
  output logic [MAX_W-1:0]      ext_o
);

  logic [MAX_W-1:0] sr_q, sr_d;
  int               top_idx;
  logic             msb;

  always_comb begin
    sr_d = tick_i ? {sr_q[MAX_W-2:0], sd_i} : sr_q;
  end

  always_comb begin
    top_idx = int'(width_i) - 1;
    if (top_idx < 0)         top_idx = 0;
    if (top_idx > MAX_W - 1) top_idx = MAX_W - 1;
    msb = sr_q[top_idx];
    for (int i = 0; i < MAX_W; i++) ext_o[i] = (i <= top_idx) ? sr_q[i] : msb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

endmodule

// File: rtl/rjrx_top.sv
module rjrx_top
  import rjrx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_clk,
  input  logic             frame_sel,
  input  logic             ser_data,
  input  logic             pack_mode,
  input  logic [1:0]       word_len,
  output logic [MAX_W-1:0] left_sample,
  output logic [MAX_W-1:0] right_sample,
  output logic             pair_valid,
  output logic             frame_err
);

  logic rst_meta_q, srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      srst_n     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      srst_n     <= rst_meta_q;
    end
  end

  logic                  bit_tick, lr_s, sd_s;
  logic                  cap_right, pair_go, len_err;
  logic [WIDTH_BITS-1:0] width;
  logic [MAX_W-1:0]      ext;

  rjrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(srst_n),
    .bclk_i(bit_clk), .lrck_i(frame_sel), .sd_i(ser_data),
    .tick_o(bit_tick), .lr_o(lr_s), .sd_o(sd_s)
  );

  rjrx_framer u_framer (
    .clk(clk), .rst_n(srst_n),
    .tick_i(bit_tick), .lr_i(lr_s), .pack_i(pack_mode),
    .cap_right_o(cap_right), .go_o(pair_go), .err_o(len_err)
  );

  assign width = sample_bits(pack_mode, wlen_e'(word_len));

  rjrx_shift u_shift (
    .clk(clk), .rst_n(srst_n),
    .tick_i(bit_tick), .sd_i(sd_s), .width_i(width), .ext_o(ext)
  );

  logic [MAX_W-1:0] rhold_q, rhold_d;
  logic [MAX_W-1:0] lstage_q, lstage_d, rstage_q, rstage_d;
  logic [MAX_W-1:0] lout_q, lout_d, rout_q, rout_d;
  logic             pend_q, pend_d, valid_q, valid_d, err_q, err_d;

  always_comb begin
    rhold_d  = rhold_q;
    lstage_d = lstage_q;
    rstage_d = rstage_q;
    lout_d   = lout_q;
    rout_d   = rout_q;
    pend_d   = pend_q;
    valid_d  = 1'b0;
    err_d    = len_err;
    if (cap_right) rhold_d = ext;
    if (pair_go) begin
      lstage_d = ext;
      rstage_d = rhold_q;
      pend_d   = 1'b1;
    end else if (bit_tick && pend_q) begin
      lout_d  = lstage_q;
      rout_d  = rstage_q;
      valid_d = 1'b1;
      pend_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rhold_q  <= '0;
      lstage_q <= '0;
      rstage_q <= '0;
      lout_q   <= '0;
      rout_q   <= '0;
      pend_q   <= 1'b0;
      valid_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      rhold_q  <= rhold_d;
      lstage_q <= lstage_d;
      rstage_q <= rstage_d;
      lout_q   <= lout_d;
      rout_q   <= rout_d;
      pend_q   <= pend_d;
      valid_q  <= valid_d;
      err_q    <= err_d;
    end
  end

  assign left_sample  = lout_q;
  assign right_sample = rout_q;
  assign pair_valid   = valid_q;
  assign frame_err    = err_q;

  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!srst_n)
    pair_valid |=> !pair_valid);

  p_hold_outputs_r5: assert property (@(posedge clk) disable iff (!srst_n)
    !pair_valid |-> ($stable(left_sample) && $stable(right_sample)));

  p_valid_on_bit_edge_r5: assert property (@(posedge clk) disable iff (!srst_n)
    pair_valid |-> $past(bit_tick));

  p_err_pulse_r7: assert property (@(posedge clk) disable iff (!srst_n)
    frame_err |=> !frame_err);

endmodule

// File: tb/sim_rjrx_top.sv
module sim_rjrx_top;

  localparam int CLK_PERIOD = 10;
  localparam int BCLK_HALF  = 4;

  logic        clk = 1'b0;
  logic        rst_n, bit_clk, frame_sel, ser_data, pack_mode;
  logic [1:0]  word_len;
  logic [23:0] left_sample, right_sample;
  logic        pair_valid, frame_err;

  rjrx_top u0 (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .frame_sel(frame_sel),
    .ser_data(ser_data), .pack_mode(pack_mode), .word_len(word_len),
    .left_sample(left_sample), .right_sample(right_sample),
    .pair_valid(pair_valid), .frame_err(frame_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int          checks = 0, errors = 0;
  int          vcnt = 0, ecnt = 0, rise_cnt = 0, got_pos = 0;
  logic [23:0] got_l = '0, got_r = '0;
  logic [31:0] seed = 32'h1234_5678;
  bit          done = 0;
  bit          has_prev = 0, prev_bad_left = 0;
  logic [23:0] pl = '0, pr = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pair_valid) begin
        vcnt++;
        got_l   = left_sample;
        got_r   = right_sample;
        got_pos = rise_cnt;
      end
      if (frame_err) ecnt++;
    end
  end

  task automatic check_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int wbits(input bit pk, input logic [1:0] wl);
    if (pk) return 16;
    case (wl)
      2'b00:   return 24;
      2'b01:   return 20;
      2'b10:   return 18;
      default: return 16;
    endcase
  endfunction

  function automatic logic [23:0] sext(input logic [23:0] v, input int w);
    logic [23:0] m, r;
    m = (24'h1 << w) - 24'h1;
    r = v & m;
    if (r[w-1]) r = r | ~m;
    return r;
  endfunction

  function automatic logic [23:0] lcg();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed[31:8];
  endfunction

  task automatic bitstep(input logic lr, input logic d);
    if (frame_sel && !lr) rise_cnt = 0;
    frame_sel = lr;
    ser_data  = d;
    bit_clk   = 1'b0;
    repeat (BCLK_HALF) @(negedge clk);
    bit_clk = 1'b1;
    rise_cnt++;
    repeat (BCLK_HALF) @(negedge clk);
  endtask

  task automatic send_half(input logic lr, input logic [23:0] v, input int n, input int w,
                           input bit chg, input logic [1:0] nwl);
    logic [23:0] junk;
    junk = lcg();
    for (int k = 0; k < n; k++) begin
      int   idx;
      logic b;
      idx = n - 1 - k;
      b   = (idx < w) ? v[idx] : junk[k % 24];
      if (chg && k == 4) word_len = nwl;
      bitstep(lr, b);
    end
  endtask

  // one frame: right half (frame_sel=0) then left half (frame_sel=1)
  task automatic send_frame(input logic [23:0] lv, input logic [23:0] rv,
                            input int nr, input int nl, input logic [1:0] wl,
                            input string req);
    int hl, w, v0, e0, v1, e1;
    hl = pack_mode ? 16 : 32;
    w  = wbits(pack_mode, wl);
    v0 = vcnt;
    e0 = ecnt;
    send_half(1'b0, rv, nr, w, 1'b1, wl);
    if (has_prev) begin
      check_eq("R2", "pair delivered", vcnt, v0 + 1);
      check_eq(req, "left value", got_l, pl);
      check_eq(req, "right value", got_r, pr);
      check_eq("R5", "bit clocks after close", got_pos, 2);
    end else begin
      check_eq("R1,R7", "no pair delivered", vcnt, v0);
    end
    check_eq("R7", "error after left half", ecnt, e0 + (prev_bad_left ? 1 : 0));
    v1 = vcnt;
    e1 = ecnt;
    send_half(1'b1, lv, nl, w, 1'b0, wl);
    check_eq("R7", "error after right half", ecnt, e1 + ((nr != hl) ? 1 : 0));
    check_eq("R5", "no strobe mid frame", vcnt, v1);
    has_prev      = (nr == hl) && (nl == hl);
    prev_bad_left = (nl != hl);
    pl = sext(lv, w);
    pr = sext(rv, w);
  endtask

  task automatic lead_in();
    has_prev      = 0;
    prev_bad_left = 0;
    for (int k = 0; k < 10; k++) bitstep(1'b1, k[0]);
  endtask

  task automatic do_reset();
    rst_n     = 1'b0;
    bit_clk   = 1'b0;
    frame_sel = 1'b1;
    ser_data  = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_eq("R1", "reset valid", pair_valid, 0);
    check_eq("R1", "reset err", frame_err, 0);
    check_eq("R1", "reset left", left_sample, 0);
    check_eq("R1", "reset right", right_sample, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 180000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int e_before;
    pack_mode = 1'b0;
    word_len  = 2'b00;
    do_reset();
    lead_in();
    check_eq("R1", "no error before first transition", ecnt, 0);

    // R3 R4: word-length sweep in normal mode
    for (int wl = 0; wl < 4; wl++) begin
      for (int p = 0; p < 6; p++) begin
        int          w;
        logic [23:0] lv, rv, m;
        w = wbits(1'b0, wl[1:0]);
        m = (24'h1 << w) - 24'h1;
        case (p)
          0: begin lv = 24'h0;                       rv = 24'h1; end
          1: begin lv = (24'h1 << (w - 1)) - 24'h1;  rv = 24'h1 << (w - 1); end
          2: begin lv = m;                           rv = 24'h555555 & m; end
          default: begin lv = lcg() & m;             rv = lcg() & m; end
        endcase
        send_frame(lv, rv, 32, 32, wl[1:0], "R3,R4");
      end
    end
    send_frame(24'h0, 24'h0, 32, 32, 2'b00, "R3");

    // R7 R8: length errors in normal mode
    send_frame(24'h111111, 24'h222222, 31, 32, 2'b00, "R7");
    send_frame(24'h7ABCDE, 24'h812345, 32, 32, 2'b00, "R8");
    send_frame(24'h333333, 24'h444444, 32, 33, 2'b00, "R8");
    send_frame(24'h0F0F0F, 24'hF0F0F0, 32, 32, 2'b00, "R8");
    send_frame(24'h0, 24'h0, 32, 32, 2'b00, "R8");

    // R6: packed mode, word_len has no effect
    pack_mode = 1'b1;
    do_reset();
    lead_in();
    for (int wl = 0; wl < 4; wl++) begin
      for (int p = 0; p < 4; p++) begin
        logic [23:0] lv, rv;
        case (p)
          0: begin lv = 24'h7FFF; rv = 24'h8000; end
          1: begin lv = 24'hFFFF; rv = 24'h0001; end
          default: begin lv = lcg() & 24'hFFFF; rv = lcg() & 24'hFFFF; end
        endcase
        send_frame(lv, rv, 16, 16, wl[1:0], "R6");
      end
    end
    e_before = ecnt;
    send_frame(24'h1234, 24'h5678, 17, 16, 2'b01, "R7");
    send_frame(24'hA5A5, 24'h5A5A, 16, 16, 2'b10, "R8");
    send_frame(24'h0, 24'h0, 16, 16, 2'b00, "R8");
    check_eq("R7", "packed length errors", ecnt - e_before, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule